// File: doc/BRIEF.md
# Double-Hiccup Fault Supervisor

This block is the control state machine of an offline switching controller. It decides when the start-up current source charges the supply capacitor, when the gate driver may switch, when a soft-start ramp is launched, and when the device drops into its low-current mode. All supply information arrives as digital comparator flags, one for each supply level of interest. A free-running prescaler supplies a slow tick, and every time window in the block is measured in ticks.

In normal operation the supply is kept between the minimum and the on level by toggling the start-up source, with the drive enabled. A fault sends the block into a double hiccup. Four events count as faults: a thermal flag, an accepted external latch request, an overload flag held for the whole overload window, or a supply dip below the undervoltage level that outlasts its grace window. During a double hiccup the drive is off and the supply is allowed to sag to the hiccup level and climb back to the on level twice before a soft-started retry. A lock holds the block in endless hiccup cycling until the supply collapses below the logic-reset level. The lock is set by an accepted external latch request, and by an overload when the latched variant is selected.

Top module: `hiccup_supervisor`

## Requirements
- R1: While the supply is below the logic-reset level the block sits in its power-on state with the start-up source on, drive off and low-current mode off. It stays there, with the drive off, until the supply reaches the on level.
- R2: When the supply reaches the on level from the power-on state, the drive is enabled and the start-up source switched off one clock later. The soft-start trigger pulses high for exactly one clock, in the first clock of drive.
- R3: While driving, the start-up source turns on only once the supply is below the minimum level and turns off only once it is at or above the on level. The drive stays enabled throughout.
- R4: A supply below the undervoltage level disables the drive one clock later. If the supply recovers before UVLO_TICKS ticks elapse, the drive resumes without a soft-start pulse. Otherwise a double hiccup starts.
- R5: An overload flag held high for OVLD_TICKS consecutive ticks while driving starts a fault. Any clock with the flag low restarts that window.
- R6: In a double hiccup the drive is off and low-current mode is on. The start-up source stays off until the supply falls below the hiccup level, then stays on until the supply reaches the on level. The drive restarts, with a soft-start pulse, on the second arrival at the on level.
- R7: If the thermal flag is still high when the second on-level arrival comes, the hiccup continues. Every later arrival re-evaluates, and the drive restarts at the first arrival with the flag low.
- R8: With latch_mode_i = 1 (latched variant), an overload fault locks the block: the drive is never enabled again until the supply falls below the logic-reset level. With latch_mode_i = 0 the block retries after the double hiccup.
- R9: The external latch input is accepted only after it stays high for LATCH_TICKS consecutive ticks. Shorter pulses leave the drive running. An accepted request locks the block in either variant.
- R10: A supply below the logic-reset level clears the lock, the hiccup progress and all window counters. The block then starts afresh from the power-on state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_above_on_i | input | 1 | Supply at or above the on level |
| sup_above_min_i | input | 1 | Supply at or above the minimum operating level |
| sup_above_uvlo_i | input | 1 | Supply at or above the undervoltage level |
| sup_above_hic_i | input | 1 | Supply at or above the hiccup level |
| sup_above_rst_i | input | 1 | Supply at or above the logic-reset level |
| ovld_i | input | 1 | Feedback at the open/overload level |
| therm_i | input | 1 | Thermal shutdown flag |
| ext_latch_i | input | 1 | Unfiltered external latch request |
| latch_mode_i | input | 1 | 1 = latched variant, 0 = auto-retry variant |
| src_en_o | output | 1 | Start-up current source enable |
| drv_en_o | output | 1 | Gate drive enable |
| ss_start_o | output | 1 | One-clock soft-start trigger |
| lowq_o | output | 1 | Low-current mode during hiccup |

## Verification
The assertions take the supply flags to be ordered as a real supply makes them: a flag for a higher level is never high while the flag for a lower level is low. They also take the flags to move only between clock edges. The bench derives every flag from a single modelled supply value, compared against five fixed levels at the inactive clock edge, so this ordering always holds. The model charges the supply while the source is on and drains it faster while driving. Where the bench pins the supply to fixed values to force an undervoltage dip or a logic reset, it still computes the flags from that one value.

// File: rtl/hs_pkg.sv
package hs_pkg;

  typedef enum logic [2:0] {
    ST_POR,
    ST_RUN,
    ST_GRACE,
    ST_HDIS,
    ST_HCHG
  } hs_state_e;

  typedef enum logic [2:0] {
    FC_NONE,
    FC_UVLO,
    FC_OVLD,
    FC_THERM,
    FC_LATCH
  } hs_cause_e;

  // Fixed priority among simultaneous fault events: latch, thermal, overload, UVLO.
  function automatic hs_cause_e pick_cause(input logic ev_latch, input logic ev_therm,
                                           input logic ev_ovld, input logic ev_uvlo);
    hs_cause_e c;
    if (ev_latch)      c = FC_LATCH;
    else if (ev_therm) c = FC_THERM;
    else if (ev_ovld)  c = FC_OVLD;
    else if (ev_uvlo)  c = FC_UVLO;
    else               c = FC_NONE;
    return c;
  endfunction

  // Whether a fault cause locks the block until a logic reset.
  function automatic logic cause_locks(input hs_cause_e c, input logic latched_variant);
    return (c == FC_LATCH) || ((c == FC_OVLD) && latched_variant);
  endfunction

endpackage

// File: rtl/hs_tick.sv
module hs_tick #(
  parameter int unsigned DIV = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (cnt_q == LAST)  cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/hs_window.sv
// Continuous-hold window: done_o rises once hold_i has stayed high for LIMIT ticks.
module hs_window #(
  parameter int unsigned LIMIT = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic hold_i,
  input  logic tick_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt_q <= '0;
    else if (clr_i || !hold_i)       cnt_q <= '0;
    else if (tick_i && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = (cnt_q == TOP);
endmodule

// File: rtl/hs_dss.sv
// Supply hysteresis for self-supply while operating.
module hs_dss (
  input  logic clk,
  input  logic rst_n,
  input  logic active_i,
  input  logic above_on_i,
  input  logic above_min_i,
  output logic src_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            src_o <= 1'b0;
    else if (!active_i)    src_o <= 1'b0;
    else if (!above_min_i) src_o <= 1'b1;
    else if (above_on_i)   src_o <= 1'b0;
  end
endmodule

// File: rtl/hiccup_supervisor.sv
module hiccup_supervisor #(
  parameter int unsigned TICK_DIV    = 100,
  parameter int unsigned UVLO_TICKS  = 50000,
  parameter int unsigned OVLD_TICKS  = 118000,
  parameter int unsigned LATCH_TICKS = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sup_above_on_i,
  input  logic sup_above_min_i,
  input  logic sup_above_uvlo_i,
  input  logic sup_above_hic_i,
  input  logic sup_above_rst_i,
  input  logic ovld_i,
  input  logic therm_i,
  input  logic ext_latch_i,
  input  logic latch_mode_i,
  output logic src_en_o,
  output logic drv_en_o,
  output logic ss_start_o,
  output logic lowq_o
);
  import hs_pkg::*;

  hs_state_e state_q, state_d;
  logic      reach_q, reach_d;   // first on-level arrival of the hiccup seen
  logic      lock_q, lock_d;
  logic      ss_q, ss_d;

  // Named internal events
  logic tick;
  logic force_por;
  logic in_run, in_grace, in_op;
  logic ovld_done, uvlo_done, latch_done;
  logic dss_src;
  logic fault_go;
  logic restart_blocked;
  hs_cause_e cause;

  assign force_por = !sup_above_rst_i;
  assign in_run    = (state_q == ST_RUN);
  assign in_grace  = (state_q == ST_GRACE);
  assign in_op     = in_run || in_grace;

  hs_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick_o(tick)
  );

  hs_window #(.LIMIT(OVLD_TICKS)) u_ovld_win (
    .clk(clk), .rst_n(rst_n), .clr_i(force_por),
    .hold_i(ovld_i && in_run), .tick_i(tick), .done_o(ovld_done)
  );

  hs_window #(.LIMIT(UVLO_TICKS)) u_uvlo_win (
    .clk(clk), .rst_n(rst_n), .clr_i(force_por),
    .hold_i(in_grace && !sup_above_uvlo_i), .tick_i(tick), .done_o(uvlo_done)
  );

  hs_window #(.LIMIT(LATCH_TICKS)) u_latch_win (
    .clk(clk), .rst_n(rst_n), .clr_i(force_por),
    .hold_i(ext_latch_i), .tick_i(tick), .done_o(latch_done)
  );

  hs_dss u_dss (
    .clk(clk), .rst_n(rst_n), .active_i(in_op && !force_por),
    .above_on_i(sup_above_on_i), .above_min_i(sup_above_min_i), .src_o(dss_src)
  );

  assign cause = in_op ? pick_cause(latch_done, therm_i, ovld_done && in_run, uvlo_done)
                       : FC_NONE;
  assign fault_go        = (cause != FC_NONE);
  assign restart_blocked = lock_q || latch_done || therm_i;

  always_comb begin
    state_d = state_q;
    reach_d = reach_q;
    ss_d    = 1'b0;
    lock_d  = lock_q || latch_done || (fault_go && cause_locks(cause, latch_mode_i));
    unique case (state_q)
      ST_POR: begin
        if (sup_above_on_i) begin
          if (restart_blocked) begin
            state_d = ST_HDIS;
            reach_d = 1'b1;
          end else begin
            state_d = ST_RUN;
            ss_d    = 1'b1;
          end
        end
      end
      ST_RUN: begin
        if (fault_go) begin
          state_d = ST_HDIS;
          reach_d = 1'b0;
        end else if (!sup_above_uvlo_i) begin
          state_d = ST_GRACE;
        end
      end
      ST_GRACE: begin
        if (fault_go) begin
          state_d = ST_HDIS;
          reach_d = 1'b0;
        end else if (sup_above_uvlo_i) begin
          state_d = ST_RUN;
        end
      end
      ST_HDIS: begin
        if (!sup_above_hic_i) state_d = ST_HCHG;
      end
      ST_HCHG: begin
        if (sup_above_on_i) begin
          if (!reach_q) begin
            state_d = ST_HDIS;
            reach_d = 1'b1;
          end else if (restart_blocked) begin
            state_d = ST_HDIS;
          end else begin
            state_d = ST_RUN;
            reach_d = 1'b0;
            ss_d    = 1'b1;
          end
        end
      end
      default: state_d = ST_POR;
    endcase
    if (force_por) begin
      state_d = ST_POR;
      reach_d = 1'b0;
      lock_d  = 1'b0;
      ss_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_POR;
      reach_q <= 1'b0;
      lock_q  <= 1'b0;
      ss_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      reach_q <= reach_d;
      lock_q  <= lock_d;
      ss_q    <= ss_d;
    end
  end

  assign drv_en_o   = in_run;
  assign lowq_o     = (state_q == ST_HDIS) || (state_q == ST_HCHG);
  assign src_en_o   = (state_q == ST_POR) || (state_q == ST_HCHG) || (in_op && dss_src);
  assign ss_start_o = ss_q;

endmodule

// File: rtl/hs_checker.sv
module hs_checker (
  input logic clk,
  input logic rst_n,
  input logic sup_above_on,
  input logic sup_above_uvlo,
  input logic sup_above_rst,
  input logic src_en,
  input logic drv_en,
  input logic ss_start,
  input logic lowq,
  input logic lock
);
  // R1: a collapsed supply puts the block into the charging power-on state
  a_r1_por_after_collapse: assert property (@(posedge clk) disable iff (!rst_n)
    !sup_above_rst |=> (src_en && !drv_en && !lowq));

  // R2: the soft-start trigger only appears together with the drive
  a_r2_ss_with_drive: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start |-> drv_en);

  // R2: the soft-start trigger lasts one clock
  a_r2_ss_single: assert property (@(posedge clk) disable iff (!rst_n)
    ss_start |=> !ss_start);

  // R4: an undervoltage dip cuts the drive on the next clock
  a_r4_uvlo_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_en && !sup_above_uvlo) |=> !drv_en);

  // R6: low-current mode never overlaps the drive
  a_r6_lowq_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
    lowq |-> !drv_en);

  // R6: reaching the on level during a hiccup stops the source
  a_r6_src_stops_at_on: assert property (@(posedge clk) disable iff (!rst_n)
    (lowq && sup_above_on && sup_above_rst) |=> !src_en);

  // R8: a locked block never drives
  a_r8_lock_blocks_drive: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> !drv_en);
endmodule

bind hiccup_supervisor hs_checker u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .sup_above_on(sup_above_on_i),
  .sup_above_uvlo(sup_above_uvlo_i),
  .sup_above_rst(sup_above_rst_i),
  .src_en(src_en_o),
  .drv_en(drv_en_o),
  .ss_start(ss_start_o),
  .lowq(lowq_o),
  .lock(lock_q)
);

// File: tb/hiccup_supervisor_tb.sv
module hiccup_supervisor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DIV   = 4;
  localparam int UVT   = 10;
  localparam int OVT   = 20;
  localparam int LAT   = 5;
  // supply levels in mV
  localparam int V_ON  = 12700;
  localparam int V_MIN = 9900;
  localparam int V_UV  = 9400;
  localparam int V_HIC = 5700;
  localparam int V_RST = 4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_on, a_min, a_uv, a_hic, a_rst;
  logic ovld = 1'b0, therm = 1'b0, xl = 1'b0, lmode = 1'b0;
  logic src, drv, ss, lowq;

  always #(CLK_PERIOD/2) clk = ~clk;

  hiccup_supervisor #(.TICK_DIV(DIV), .UVLO_TICKS(UVT), .OVLD_TICKS(OVT), .LATCH_TICKS(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .sup_above_on_i(a_on), .sup_above_min_i(a_min), .sup_above_uvlo_i(a_uv),
    .sup_above_hic_i(a_hic), .sup_above_rst_i(a_rst),
    .ovld_i(ovld), .therm_i(therm), .ext_latch_i(xl), .latch_mode_i(lmode),
    .src_en_o(src), .drv_en_o(drv), .ss_start_o(ss), .lowq_o(lowq)
  );

  int n_chk = 0, n_fail = 0;
  int vcc = 0;
  bit model_en = 1'b0;
  bit drv_prev = 1'b0, src_prev = 1'b0;
  bit drv_seen = 1'b0, drv_fell = 1'b0;
  int ss_cnt = 0, reach_cnt = 0, last_reach = -1;
  int v_src_rise = 0, v_src_fall = 0, v_lowq_min = 99999, v_drv_rise = 0;
  bit src_bad = 1'b0;

  task automatic apply_flags();
    a_on  = (vcc >= V_ON);
    a_min = (vcc >= V_MIN);
    a_uv  = (vcc >= V_UV);
    a_hic = (vcc >= V_HIC);
    a_rst = (vcc >= V_RST);
  endtask

  task automatic check(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // One clock: observe outputs, then move the supply model.
  task automatic step();
    int prev;
    @(negedge clk);
    if (drv) drv_seen = 1'b1;
    if (!drv && drv_prev) drv_fell = 1'b1;
    if (drv && !drv_prev) begin last_reach = reach_cnt; v_drv_rise = vcc; end
    if (ss) ss_cnt++;
    if (drv && src && !src_prev) begin v_src_rise = vcc; if (vcc >= V_MIN) src_bad = 1'b1; end
    if (drv && !src && src_prev) begin v_src_fall = vcc; if (vcc < V_ON) src_bad = 1'b1; end
    if (lowq && vcc < v_lowq_min) v_lowq_min = vcc;
    drv_prev = drv;
    src_prev = src;
    prev = vcc;
    if (model_en) begin
      if (src) vcc += 100;
      vcc -= drv ? 60 : 20;
      if (vcc < 0) vcc = 0;
    end
    if (lowq && prev < V_ON && vcc >= V_ON) reach_cnt++;
    apply_flags();
  endtask

  task automatic steps(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic wait_drv(input int max);
    for (int i = 0; i < max && !drv; i++) step();
  endtask

  initial begin
    #(CLK_PERIOD * 180000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int ss0;
    apply_flags();
    steps(3);
    // R1: reset / collapsed supply state
    check(src == 1 && drv == 0 && lowq == 0 && ss == 0, "R1 por outputs src,drv,lowq,ss",
          {src, drv, lowq, ss}, 4'b1000);
    rst_n = 1'b1;
    model_en = 1'b1;
    wait_drv(400);
    check(drv == 1, "R2 drive after start-up", drv, 1);
    check(v_drv_rise >= V_ON, "R1 drive held off below on level", v_drv_rise, V_ON);
    check(ss == 1 && ss_cnt == 1, "R2 soft-start pulse with first drive", ss_cnt, 1);
    check(src == 0, "R2 source off when driving", src, 0);
    step();
    check(ss == 0, "R2 soft-start lasts one clock", ss, 0);

    // R3: self-supply hysteresis while driving
    drv_fell = 0; src_bad = 0; v_src_rise = 0; v_src_fall = 0;
    steps(400);
    check(drv_fell == 0, "R3 drive stays on", drv_fell, 0);
    check(v_src_rise > 0 && src_bad == 0, "R3 source turn-on below min", v_src_rise, V_MIN - 1);
    check(v_src_fall >= V_ON && src_bad == 0, "R3 source turn-off at on", v_src_fall, V_ON);

    // R5: overload hold sweep, shorter than the window
    for (int k = 1; k < OVT; k++) begin
      drv_fell = 0;
      ovld = 1'b1; steps(k * DIV);
      ovld = 1'b0; steps(3);
      check(drv_fell == 0 && drv == 1, $sformatf("R5 overload held %0d ticks ignored", k), drv_fell, 0);
    end
    reach_cnt = 0; v_lowq_min = 99999; ss0 = ss_cnt;
    ovld = 1'b1; steps((OVT + 2) * DIV);
    check(lowq == 1 && drv == 0, "R5 overload window expiry faults", lowq, 1);
    ovld = 1'b0;

    // R6 / R8 auto-retry: restart at second on-level arrival
    wait_drv(3000);
    check(drv == 1 && last_reach == 2, "R6 restart at second on arrival", last_reach, 2);
    check(ss_cnt == ss0 + 1, "R6 soft-start on restart", ss_cnt - ss0, 1);
    check(v_lowq_min < V_HIC && v_lowq_min >= V_HIC - 40, "R6 discharge to hiccup level", v_lowq_min, V_HIC - 20);
    check(drv == 1, "R8 auto-retry variant restarts after overload", drv, 1);

    // R7: thermal flag blocks the restart
    steps(20);
    therm = 1'b1; step();
    check(drv == 0 && lowq == 1, "R7 thermal fault enters hiccup", lowq, 1);
    reach_cnt = 0; drv_seen = 0;
    for (int i = 0; i < 4000 && reach_cnt < 3; i++) step();
    steps(5);
    check(drv_seen == 0, "R7 no drive while thermal persists", drv_seen, 0);
    therm = 1'b0;
    wait_drv(3000);
    check(drv == 1 && last_reach == 4, "R7 restart at first clear arrival", last_reach, 4);

    // R4: undervoltage grace
    steps(20);
    ss0 = ss_cnt;
    model_en = 0; vcc = 9000; apply_flags();
    step();
    check(drv == 0, "R4 drive cut one clock after dip", drv, 0);
    steps(4);
    vcc = 11000; apply_flags();
    steps(2);
    check(drv == 1 && lowq == 0, "R4 drive resumes after short dip", drv, 1);
    check(ss_cnt == ss0, "R4 no soft-start on recovery", ss_cnt - ss0, 0);
    vcc = 9000; apply_flags();
    steps((UVT + 2) * DIV);
    check(lowq == 1 && drv == 0, "R4 long dip starts hiccup", lowq, 1);
    reach_cnt = 0; model_en = 1;
    wait_drv(3000);
    check(drv == 1 && last_reach == 2, "R4 retry after undervoltage hiccup", last_reach, 2);

    // R9: external latch filter sweep
    steps(20);
    for (int k = 1; k < LAT; k++) begin
      drv_fell = 0;
      xl = 1'b1; steps(k * DIV);
      xl = 1'b0; steps(3);
      check(drv_fell == 0 && drv == 1, $sformatf("R9 latch pulse %0d ticks ignored", k), drv_fell, 0);
    end
    xl = 1'b1; steps((LAT + 2) * DIV);
    check(lowq == 1 && drv == 0, "R9 held latch accepted", lowq, 1);
    xl = 1'b0;
    drv_seen = 0; reach_cnt = 0;
    steps(3000);
    check(drv_seen == 0 && reach_cnt >= 3, "R9 latch locks auto variant", drv_seen, 0);

    // R10: logic reset clears the lock
    model_en = 0; vcc = 3000; apply_flags();
    steps(2);
    check(src == 1 && drv == 0 && lowq == 0, "R10 collapse returns to power-on", {src, drv, lowq}, 3'b100);
    model_en = 1; ss0 = ss_cnt;
    wait_drv(400);
    check(drv == 1 && ss_cnt == ss0 + 1, "R10 fresh start after logic reset", drv, 1);

    // R8: latched variant overload
    steps(20);
    lmode = 1'b1;
    ovld = 1'b1; steps((OVT + 2) * DIV);
    check(lowq == 1, "R8 latched overload enters hiccup", lowq, 1);
    ovld = 1'b0;
    drv_seen = 0; reach_cnt = 0;
    steps(3000);
    check(drv_seen == 0 && reach_cnt >= 3, "R8 latched variant never drives", drv_seen, 0);
    model_en = 0; vcc = 3000; apply_flags();
    steps(2);
    model_en = 1;
    wait_drv(400);
    check(drv == 1, "R8 latched variant clears on logic reset", drv, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule